// File: doc/BRIEF.md
# Cross-Instrument Trigger Router

This block distributes trigger events among the instruments of a mixed-signal acquisition and generation system. Each instrument (scope, waveform generator, logic analyzer, pattern generator) raises a trigger line when its own condition is met. External trigger pins are also sources. A programmable selector chooses, for every instrument trigger input and every external trigger output pin, which source drives it. Any source can therefore start any instrument, and one unit can start another unit through the external pins.

Instrument-to-destination paths are purely combinational, so a trigger reaches its destination in the same cycle it is raised and the instruments stay in step. External inputs are asynchronous. They pass through a two-flop synchroniser and can optionally be reduced to a single-cycle pulse on their rising edge. A simple write port loads the configuration. Routing selections only change while the router is disarmed, which keeps a half-written configuration from producing stray triggers.

Top module: `trig_xbar`

## Requirements
- R1: A destination whose select code is 0 is held low.
- R2: Select codes 1..N_INST route instrument trigger `code-1` to the destination combinationally, in the same cycle. This applies to instrument inputs and external outputs alike.
- R3: Select codes N_INST+1..N_INST+N_EXT_IN route external pin `code-N_INST-1`. With its edge-mask bit clear, the destination follows the pin level after exactly two rising clock edges.
- R4: With the edge-mask bit of an external pin set, a rising edge on that pin produces a pulse one cycle wide. The pulse appears on the routed destination after the second clock edge. A pin held high produces no further pulse.
- R5: Select codes above N_INST+N_EXT_IN route nothing, and the destination is held low.
- R6: While the armed bit (bit 0 at address NDST) is clear, every destination is low. The only exception is an external output with forcing enabled.
- R7: Writes to the select registers (address d for destination d) and to the edge mask (address NDST+1, bit j for pin j) are ignored while armed. The armed bit is always writable.
- R8: The force register sits at address NDST+2. Its bits [N_EXT_OUT-1:0] enable forcing and its bits [2*N_EXT_OUT-1:N_EXT_OUT] give the levels. A forced external output shows its level whatever the arming and selection.
- R9: After reset the router is disarmed, all selects and the edge mask are 0, forcing is off, and every output is low.
- R10: One source may drive several destinations at the same time.

Destination order is instrument inputs 0..N_INST-1, then external outputs 0..N_EXT_OUT-1. A write takes effect at the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| inst_fire_i | input | N_INST | Trigger raised by each instrument |
| ext_pin_i | input | N_EXT_IN | Asynchronous external trigger pins |
| inst_start_o | output | N_INST | Trigger delivered to each instrument |
| ext_pin_o | output | N_EXT_OUT | External trigger output pins |

## Verification
The embedded assertions check several properties on every cycle:
- A zero or disarmed selection never drives a destination high.
- Forcing always wins on an external output.
- The routing and edge-mask registers stay frozen across any cycle that starts armed.
- An edge-mode pulse never lasts two cycles.

Other behaviour is shown only by the bench's scenarios:
- The mapping of each select code to its source, swept over all codes with all instrument and pin patterns.
- The exact two-edge latency of the synchroniser.
- The timing of the rising-edge pulse.
- The fact that a write made while armed has no effect on the outputs.

// File: rtl/trig_xbar_pkg.sv
package trig_xbar_pkg;

  typedef enum logic [2:0] {
    RK_SEL,
    RK_CTRL,
    RK_EDGE,
    RK_FORCE,
    RK_NONE
  } reg_kind_e;

  // Address map: selects first, then control, edge mask, force.
  function automatic reg_kind_e classify(input int unsigned a, input int unsigned ndst);
    if (a < ndst)          return RK_SEL;
    else if (a == ndst)    return RK_CTRL;
    else if (a == ndst+1)  return RK_EDGE;
    else if (a == ndst+2)  return RK_FORCE;
    else                   return RK_NONE;
  endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_xbar_pkg::*;
#(
  parameter int NDST      = 6,
  parameter int SEL_W     = 3,
  parameter int N_EXT_IN  = 2,
  parameter int N_EXT_OUT = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [NDST-1:0][SEL_W-1:0] sel_o,
  output logic                       armed_o,
  output logic [N_EXT_IN-1:0]        edge_o,
  output logic [N_EXT_OUT-1:0]       fen_o,
  output logic [N_EXT_OUT-1:0]       flvl_o
);

  reg_kind_e kind;
  logic      cfg_open;
  logic      unused_wdata;

  assign kind         = classify(32'(addr_i), NDST);
  assign cfg_open     = we_i && !armed_o;
  assign unused_wdata = ^wdata_i;

  for (genvar d = 0; d < NDST; d++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sel_o[d] <= '0;
      else if (cfg_open && kind == RK_SEL && addr_i == ADDR_W'(d))
        sel_o[d] <= wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      edge_o  <= '0;
      fen_o   <= '0;
      flvl_o  <= '0;
    end else begin
      if (we_i && kind == RK_CTRL)     armed_o <= wdata_i[0];
      if (cfg_open && kind == RK_EDGE) edge_o  <= wdata_i[N_EXT_IN-1:0];
      if (we_i && kind == RK_FORCE) begin
        fen_o  <= wdata_i[N_EXT_OUT-1:0];
        flvl_o <= wdata_i[2*N_EXT_OUT-1:N_EXT_OUT];
      end
    end
  end

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> $stable(sel_o)); // R7
  AST_EDGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o |=> $stable(edge_o)); // R7

endmodule

// File: rtl/trig_ext_sync.sv
module trig_ext_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic edge_en_i,
  output logic trig_o
);

  logic meta_q, sync_q, hist_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign rise   = sync_q && !hist_q;
  assign trig_o = edge_en_i ? rise : sync_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_en_i && trig_o) |=> !trig_o); // R4

endmodule

// File: rtl/trig_route_mux.sv
module trig_route_mux #(
  parameter int NSRC  = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             armed_i,
  input  logic [NSRC-1:0]  src_i,
  output logic             dst_o
);

  // Code 0 and codes past the last source select nothing.
  function automatic logic pick(input logic [SEL_W-1:0] s, input logic [NSRC-1:0] v);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (32'(s) == k + 1) r = v[k];
    return r;
  endfunction

  assign dst_o = armed_i && pick(sel_i, src_i);

  AST_SEL_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == '0) |-> !dst_o); // R1
  AST_CODE_RANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sel_i) > NSRC) |-> !dst_o); // R5

endmodule

// File: rtl/trig_xbar.sv
module trig_xbar #(
  parameter int N_INST    = 4,
  parameter int N_EXT_IN  = 2,
  parameter int N_EXT_OUT = 2,
  parameter int DATA_W    = 8,
  localparam int NSRC     = N_INST + N_EXT_IN,
  localparam int NDST     = N_INST + N_EXT_OUT,
  localparam int SEL_W    = $clog2(NSRC + 1),
  localparam int ADDR_W   = $clog2(NDST + 3)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic [N_INST-1:0]    inst_fire_i,
  input  logic [N_EXT_IN-1:0]  ext_pin_i,
  output logic [N_INST-1:0]    inst_start_o,
  output logic [N_EXT_OUT-1:0] ext_pin_o
);

  logic [NDST-1:0][SEL_W-1:0] sel;
  logic                       armed;
  logic [N_EXT_IN-1:0]        edge_en;
  logic [N_EXT_OUT-1:0]       fen, flvl;
  logic [N_EXT_IN-1:0]        ext_trig;
  logic [NSRC-1:0]            src_vec;
  logic [NDST-1:0]            routed;

  trig_cfg_regs #(
    .NDST(NDST), .SEL_W(SEL_W), .N_EXT_IN(N_EXT_IN),
    .N_EXT_OUT(N_EXT_OUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .sel_o(sel), .armed_o(armed),
    .edge_o(edge_en), .fen_o(fen), .flvl_o(flvl)
  );

  for (genvar j = 0; j < N_EXT_IN; j++) begin : g_sync
    trig_ext_sync u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i[j]),
      .edge_en_i(edge_en[j]), .trig_o(ext_trig[j])
    );
  end

  assign src_vec = {ext_trig, inst_fire_i};

  for (genvar d = 0; d < NDST; d++) begin : g_route
    trig_route_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .sel_i(sel[d]), .armed_i(armed),
      .src_i(src_vec), .dst_o(routed[d])
    );
  end

  assign inst_start_o = routed[N_INST-1:0];

  for (genvar o = 0; o < N_EXT_OUT; o++) begin : g_out
    assign ext_pin_o[o] = fen[o] ? flvl[o] : routed[N_INST+o];

    AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      fen[o] |-> (ext_pin_o[o] == flvl[o])); // R8
    AST_IDLE_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !fen[o]) |-> !ext_pin_o[o]); // R6
  end

  AST_IDLE_INST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (inst_start_o == '0)); // R6

endmodule

// File: tb/trig_xbar_tb.sv
module trig_xbar_tb;

  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL  = 6;
  localparam int A_EDGE  = 7;
  localparam int A_FORCE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] inst_fire_i = '0;
  logic [1:0] ext_pin_i = '0;
  logic [3:0] inst_start_o;
  logic [1:0] ext_pin_o;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_xbar u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .inst_fire_i(inst_fire_i), .ext_pin_i(ext_pin_i),
    .inst_start_o(inst_start_o), .ext_pin_o(ext_pin_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Expected destination value from the requirements.
  function automatic logic exp_dst(input int code, input logic [3:0] inst,
                                   input logic [1:0] ext, input logic armed);
    if (!armed || code == 0) return 1'b0;
    if (code <= 4) return inst[code-1];
    if (code <= 6) return ext[code-5];
    return 1'b0;
  endfunction

  function automatic string tag_of(input int code);
    if (code == 0) return "R1";
    if (code <= 4) return "R2";
    if (code <= 6) return "R3";
    return "R5";
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    inst_fire_i = 4'hF;
    ext_pin_i = 2'b11;
    repeat (3) @(negedge clk);
    chk("R9 in reset", {2'b0, ext_pin_o, inst_start_o}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 after reset", {2'b0, ext_pin_o, inst_start_o}, 8'h00);

    // Sweep: every code on every destination, all instrument/pin patterns (R1 R2 R3 R5 R10)
    for (int base = 0; base < 8; base++) begin
      wr(A_CTRL, 0);
      for (int d = 0; d < 6; d++) wr(d, (base + d) % 8);
      chk("R6 disarmed", {2'b0, ext_pin_o, inst_start_o}, 8'h00);
      wr(A_CTRL, 1);
      for (int p = 0; p < 64; p++) begin
        inst_fire_i = 4'(p);
        ext_pin_i = 2'(p >> 4);
        repeat (2) @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < 6; d++) begin
          logic act;
          act = (d < 4) ? inst_start_o[d] : ext_pin_o[d-4];
          chk(tag_of((base + d) % 8), 8'(act),
              8'(exp_dst((base + d) % 8, inst_fire_i, ext_pin_i, 1'b1)));
        end
      end
    end

    // R10: one source fans out to all destinations
    wr(A_CTRL, 0);
    for (int d = 0; d < 6; d++) wr(d, 3);
    wr(A_CTRL, 1);
    inst_fire_i = 4'b0100;
    #1;
    chk("R10 fanout high", {2'b0, ext_pin_o, inst_start_o}, 8'h3F);
    inst_fire_i = 4'b1011;
    #1;
    chk("R10 fanout low", {2'b0, ext_pin_o, inst_start_o}, 8'h00);

    // R7: writes while armed are ignored
    wr(0, 0);
    wr(A_EDGE, 3);
    wr(1, 5);
    inst_fire_i = 4'b0100;
    #1;
    chk("R7 sel kept", 8'(inst_start_o[0]), 8'h1);
    chk("R7 sel1 kept", 8'(inst_start_o[1]), 8'h1);
    wr(A_CTRL, 0);
    wr(1, 5);
    wr(A_CTRL, 1);
    ext_pin_i = 2'b00;
    repeat (3) @(negedge clk);
    ext_pin_i = 2'b01;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R7 edge mask kept", 8'(inst_start_o[1]), (k >= 1) ? 8'h1 : 8'h0);
    end

    // R6: disarming silences routed destinations
    wr(A_CTRL, 0);
    inst_fire_i = 4'hF;
    #1;
    chk("R6 silent", {2'b0, ext_pin_o, inst_start_o}, 8'h00);

    // R8: forced external outputs
    wr(A_FORCE, 8'b0101);
    chk("R8 force high disarmed", 8'(ext_pin_o), 8'b01);
    wr(A_CTRL, 1);
    inst_fire_i = 4'b0000;
    #1;
    chk("R8 force vs low src", 8'(ext_pin_o[0]), 8'h1);
    wr(A_FORCE, 8'b0001);
    inst_fire_i = 4'b0100;
    #1;
    chk("R8 force low vs high src", 8'(ext_pin_o[0]), 8'h0);
    chk("R8 unforced follows", 8'(ext_pin_o[1]), 8'h1);
    wr(A_FORCE, 0);
    chk("R2 force released", 8'(ext_pin_o[0]), 8'h1);

    // R4: rising-edge pulse mode on pin 0
    wr(A_CTRL, 0);
    wr(A_EDGE, 1);
    wr(0, 5);
    wr(A_CTRL, 1);
    ext_pin_i = 2'b00;
    repeat (4) @(negedge clk);
    chk("R4 idle", 8'(inst_start_o[0]), 8'h0);
    for (int rep = 0; rep < 2; rep++) begin
      ext_pin_i = 2'b01;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk("R4 pulse", 8'(inst_start_o[0]), (k == 1) ? 8'h1 : 8'h0);
      end
      ext_pin_i = 2'b00;
      repeat (4) @(negedge clk);
      chk("R4 low after fall", 8'(inst_start_o[0]), 8'h0);
    end

    // R3: level mode latency on pin 1
    wr(A_CTRL, 0);
    wr(A_EDGE, 0);
    wr(2, 6);
    wr(A_CTRL, 1);
    ext_pin_i = 2'b10;
    @(negedge clk);
    chk("R3 not yet", 8'(inst_start_o[2]), 8'h0);
    @(negedge clk);
    chk("R3 two edges", 8'(inst_start_o[2]), 8'h1);

    finish_run();
  end

endmodule